// File: doc/BRIEF.md
# Multi-Lane Byte Merger

This block sits between the lane outputs of a serial camera receiver and the packet layer that parses its traffic. Up to four receive lanes each hand over one byte per byte-clock cycle, with a per-lane valid and a per-lane high-speed-active flag. The merger re-assembles the original byte order and delivers one 32-bit little-endian word at a time, with a byte-enable mask, on the same byte clock.

The byte order is round-robin: packet byte k travels on lane k mod N, where N is the number of active lanes, and lane 0 carries the first byte. A run-time setting selects N. The setting is only taken up while the link is idle, so a burst is never split across two lane counts. When a burst ends with fewer than four bytes gathered, the block flushes them as a partial word with a last flag. If the active lanes disagree about valid in one cycle, a sticky error flag is raised and that cycle's bytes are dropped.

Top module: `lane_word_merger`

## Requirements
- R1: `cfg_lanes` encodes the active lane count as value plus one (0 gives 1 lane, 3 gives 4 lanes). The active lanes are always lanes 0 through N-1.
- R2: In each accepted cycle, lane i contributes the byte that comes after the bytes of lanes 0 to i-1. Bytes fill the output word from bits 7:0 upward, so the first byte of a word is in `out_data[7:0]`.
- R3: When four bytes have been gathered, the word is presented for exactly one cycle with `out_valid`=1, `out_be`=4'b1111 and `out_last`=0. This happens on the clock edge that samples the lane cycle completing the word. Leftover bytes carry over into the next word.
- R4: A burst ends on the first edge where no active lane shows high-speed-active. If 1 to 3 bytes are pending at that edge, that edge presents them with `out_valid`=1 and `out_last`=1. The byte enables are set for the low bytes only (4'b0001, 4'b0011 or 4'b0111), and the unused upper bytes of `out_data` are zero. With nothing pending, no word is presented.
- R5: `cfg_lanes` is captured only on edges where no active lane shows high-speed-active. Changing it during a burst has no effect on that burst.
- R6: In a cycle where a burst is active and some, but not all, active lanes assert valid, `sync_err` goes to 1 on the next edge and stays at 1 until reset. The bytes of that cycle are discarded.
- R7: Data, valid and high-speed-active on lanes at index N or above have no effect on the outputs.
- R8: Lane valid while no active lane shows high-speed-active is ignored. No bytes are gathered and no word is presented.
- R9: After reset, `out_valid`, `out_last`, `out_be`, `out_data` and `sync_err` are zero, and the lane count is 1 until `cfg_lanes` is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock from the receive PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lanes | input | 2 | Active lane count minus one |
| lane_data | input | 32 | Lane bytes, lane i in bits 8i+7:8i |
| lane_valid | input | 4 | Per-lane byte valid |
| lane_hs | input | 4 | Per-lane high-speed-active indication |
| out_data | output | 32 | Merged little-endian word |
| out_be | output | 4 | Byte enables of out_data |
| out_valid | output | 1 | One-cycle strobe for a merged word |
| out_last | output | 1 | Marks the partial flush at burst end |
| sync_err | output | 1 | Sticky lane-valid mismatch flag |

## Verification
On every cycle, the embedded properties check the following:
- the byte-enable shapes (full for ordinary words, contiguous and partial for flushes);
- the bound on pending bytes;
- the freezing of the lane count during a burst;
- the stickiness of the error flag and its setting after a valid mismatch.

The byte order across lane counts, the drop of skewed cycles, and the indifference to traffic on unused lanes or outside a burst are a different matter. Only the bench's reference model can show these, by comparing every output word against a byte queue while bursts of varied lengths and lane counts run.

// File: rtl/merger_pkg.sv
package merger_pkg;

    parameter int unsigned DEF_LANES      = 4;
    parameter int unsigned DEF_BYTE_W     = 8;
    parameter int unsigned DEF_WORD_BYTES = 4;

    // width of a counter that holds the bytes buffered between words
    function automatic int unsigned pend_cnt_width(input int unsigned lanes,
                                                   input int unsigned word_bytes);
        return $clog2(word_bytes + lanes);
    endfunction

endpackage

// File: rtl/merge_lane_ctrl.sv
module merge_lane_ctrl #(
    parameter int unsigned NUM_LANES = merger_pkg::DEF_LANES,
    parameter int unsigned SEL_W     = $clog2(NUM_LANES),
    parameter int unsigned CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     cfg_lanes,
    input  logic [NUM_LANES-1:0] lane_valid,
    input  logic [NUM_LANES-1:0] lane_hs,
    output logic [NUM_LANES-1:0] lane_mask,
    output logic [CNT_W-1:0]     lane_num,
    output logic                 accept,
    output logic                 burst_end,
    output logic                 sync_err
);

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
        logic             burst;
        logic             err;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  hs_now;
    logic  all_valid;
    logic  any_valid;
    logic  skew;

    // lanes 0..cnt are in use
    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_mask[i] = (SEL_W'(i) <= c_q.cnt);
        end
    end

    always_comb begin
        hs_now    = |(lane_hs & lane_mask);
        all_valid = ((lane_valid & lane_mask) == lane_mask);
        any_valid = |(lane_valid & lane_mask);
        skew      = hs_now && any_valid && !all_valid;

        c_d       = c_q;
        c_d.burst = hs_now;
        if (!hs_now) begin
            c_d.cnt = cfg_lanes;
        end
        if (skew) begin
            c_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign lane_num  = CNT_W'(c_q.cnt) + CNT_W'(1);
    assign accept    = hs_now && all_valid;
    assign burst_end = c_q.burst && !hs_now;
    assign sync_err  = c_q.err;

    // R5: the lane count cannot move while a burst is live
    a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hs_now |=> $stable(c_q.cnt));

    // R6: once raised, the error flag never drops
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    // R6: a mismatch inside a burst is reported on the next edge
    a_r6_err_on_skew: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_now && any_valid && !all_valid) |=> sync_err);

    // R6: a skewed cycle is never taken as data
    a_r6_no_accept_on_skew: assert property (@(posedge clk) disable iff (!rst_n)
        (any_valid && !all_valid) |-> !accept);

endmodule

// File: rtl/merge_lane_gather.sv
module merge_lane_gather #(
    parameter int unsigned NUM_LANES = merger_pkg::DEF_LANES,
    parameter int unsigned BYTE_W    = merger_pkg::DEF_BYTE_W
) (
    input  logic [NUM_LANES*BYTE_W-1:0] lane_data,
    input  logic [NUM_LANES-1:0]        lane_mask,
    output logic [NUM_LANES*BYTE_W-1:0] gathered
);

    // bytes of unused lanes are forced to zero so they never reach a word
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign gathered[g*BYTE_W +: BYTE_W] =
            lane_mask[g] ? lane_data[g*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/merge_word_packer.sv
module merge_word_packer #(
    parameter int unsigned NUM_LANES  = merger_pkg::DEF_LANES,
    parameter int unsigned BYTE_W     = merger_pkg::DEF_BYTE_W,
    parameter int unsigned WORD_BYTES = merger_pkg::DEF_WORD_BYTES,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          burst_end,
    input  logic [NUM_LANES*BYTE_W-1:0]   in_bytes,
    input  logic [CNT_W-1:0]              in_cnt,
    output logic [WORD_BYTES*BYTE_W-1:0]  out_data,
    output logic [WORD_BYTES-1:0]         out_be,
    output logic                          out_valid,
    output logic                          out_last
);

    localparam int unsigned ACC_BYTES = WORD_BYTES - 1 + NUM_LANES;
    localparam int unsigned ACC_W     = ACC_BYTES * BYTE_W;
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W;

    typedef struct packed {
        logic [ACC_W-1:0]      acc;
        logic [CNT_W-1:0]      pend;
        logic [WORD_W-1:0]     data;
        logic [WORD_BYTES-1:0] be;
        logic                  valid;
        logic                  last;
    } pack_t;

    pack_t             p_d, p_q;
    logic [ACC_W-1:0]  merged;
    logic [CNT_W-1:0]  total;
    logic [WORD_BYTES-1:0] part_be;

    always_comb begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            part_be[i] = (CNT_W'(i) < p_q.pend);
        end
    end

    always_comb begin
        merged = p_q.acc | (ACC_W'(in_bytes) << (int'(p_q.pend) * BYTE_W));
        total  = p_q.pend + in_cnt;

        p_d       = p_q;
        p_d.valid = 1'b0;
        p_d.last  = 1'b0;

        if (burst_end) begin
            if (p_q.pend != '0) begin
                p_d.data  = p_q.acc[WORD_W-1:0];
                p_d.be    = part_be;
                p_d.valid = 1'b1;
                p_d.last  = 1'b1;
            end
            p_d.acc  = '0;
            p_d.pend = '0;
        end else if (accept) begin
            if (total >= CNT_W'(WORD_BYTES)) begin
                p_d.data  = merged[WORD_W-1:0];
                p_d.be    = '1;
                p_d.valid = 1'b1;
                p_d.acc   = merged >> WORD_W;
                p_d.pend  = total - CNT_W'(WORD_BYTES);
            end else begin
                p_d.acc  = merged;
                p_d.pend = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_data  = p_q.data;
    assign out_be    = p_q.be;
    assign out_valid = p_q.valid;
    assign out_last  = p_q.last;

    // R3: never more than one word's worth minus one byte is left over
    a_r3_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.pend < CNT_W'(WORD_BYTES));

    // R3: ordinary words are always complete
    a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_be == '1));

    // R4: a flushed word is partial, starts at byte 0 and is contiguous
    a_r4_last_partial: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_be != '1 && out_be[0]
                      && ((out_be & (out_be + 1'b1)) == '0)));

    // R4: after a flush nothing is left pending
    a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> (p_q.pend == '0));

endmodule

// File: rtl/lane_word_merger.sv
module lane_word_merger #(
    parameter int unsigned NUM_LANES  = merger_pkg::DEF_LANES,
    parameter int unsigned BYTE_W     = merger_pkg::DEF_BYTE_W,
    parameter int unsigned WORD_BYTES = merger_pkg::DEF_WORD_BYTES,
    parameter int unsigned SEL_W      = $clog2(NUM_LANES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              cfg_lanes,
    input  logic [NUM_LANES*BYTE_W-1:0]   lane_data,
    input  logic [NUM_LANES-1:0]          lane_valid,
    input  logic [NUM_LANES-1:0]          lane_hs,
    output logic [WORD_BYTES*BYTE_W-1:0]  out_data,
    output logic [WORD_BYTES-1:0]         out_be,
    output logic                          out_valid,
    output logic                          out_last,
    output logic                          sync_err
);

    localparam int unsigned CNT_W = merger_pkg::pend_cnt_width(NUM_LANES, WORD_BYTES);

    logic [NUM_LANES-1:0]        lane_mask;
    logic [CNT_W-1:0]            lane_num;
    logic                        accept;
    logic                        burst_end;
    logic [NUM_LANES*BYTE_W-1:0] gathered;

    merge_lane_ctrl #(
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_lanes  (cfg_lanes),
        .lane_valid (lane_valid),
        .lane_hs    (lane_hs),
        .lane_mask  (lane_mask),
        .lane_num   (lane_num),
        .accept     (accept),
        .burst_end  (burst_end),
        .sync_err   (sync_err)
    );

    merge_lane_gather #(
        .NUM_LANES (NUM_LANES),
        .BYTE_W    (BYTE_W)
    ) gather_i (
        .lane_data (lane_data),
        .lane_mask (lane_mask),
        .gathered  (gathered)
    );

    merge_word_packer #(
        .NUM_LANES  (NUM_LANES),
        .BYTE_W     (BYTE_W),
        .WORD_BYTES (WORD_BYTES),
        .CNT_W      (CNT_W)
    ) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .burst_end (burst_end),
        .in_bytes  (gathered),
        .in_cnt    (lane_num),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_valid (out_valid),
        .out_last  (out_last)
    );

    // R1: the mask always covers lane 0 and is contiguous from it
    a_r1_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask[0] && ((lane_mask & (lane_mask + 1'b1)) == '0));

    // R4: last is only ever seen together with a valid word
    a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/lane_word_merger_tb_top.sv
`timescale 1ns/1ps
module lane_word_merger_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_lanes = 2'd0;
    logic [31:0] lane_data = '0;
    logic [3:0]  lane_valid = '0;
    logic [3:0]  lane_hs = '0;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_valid;
    logic        out_last;
    logic        sync_err;

    int checks = 0;
    int failures = 0;
    string cur_req = "R9";
    int seed = 1;

    // reference model state
    byte unsigned q[$];
    int          n_m = 1;
    bit          burst_m = 0;
    bit          err_m = 0;
    logic [31:0] e_data = '0;
    logic [3:0]  e_be = '0;
    bit          e_valid = 0;
    bit          e_last = 0;

    always #2 clk = ~clk;

    lane_word_merger dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_lanes  (cfg_lanes),
        .lane_data  (lane_data),
        .lane_valid (lane_valid),
        .lane_hs    (lane_hs),
        .out_data   (out_data),
        .out_be     (out_be),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .sync_err   (sync_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural model, evaluated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            n_m = 1; burst_m = 0; err_m = 0;
            e_valid = 0; e_last = 0; e_be = '0; e_data = '0;
        end else begin
            bit hs;
            int nv;
            hs = 0;
            for (int i = 0; i < n_m; i++) hs |= lane_hs[i];
            e_valid = 0;
            e_last = 0;
            if (!hs) begin
                if (burst_m && q.size() > 0) begin
                    e_data = '0; e_be = '0;
                    for (int i = 0; i < q.size(); i++) begin
                        e_data[8*i +: 8] = q[i];
                        e_be[i] = 1'b1;
                    end
                    e_valid = 1; e_last = 1;
                    q.delete();
                end
                n_m = int'(cfg_lanes) + 1;
            end else begin
                nv = 0;
                for (int i = 0; i < n_m; i++) nv += int'(lane_valid[i]);
                if (nv == n_m) begin
                    for (int i = 0; i < n_m; i++) q.push_back(lane_data[8*i +: 8]);
                end else if (nv > 0) begin
                    err_m = 1;
                end
                if (q.size() >= 4) begin
                    e_data = {q[3], q[2], q[1], q[0]};
                    e_be = 4'hF;
                    e_valid = 1;
                    repeat (4) void'(q.pop_front());
                end
            end
            burst_m = hs;
        end
    end

    // compare half a cycle after each edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "out_valid", 32'(out_valid), 32'(e_valid));
            check("R6", "sync_err", 32'(sync_err), 32'(err_m));
            if (e_valid && out_valid) begin
                check(e_last ? "R4" : "R2", "out_data", out_data, e_data);
                check(e_last ? "R4" : "R3", "out_be", 32'(out_be), 32'(e_be));
                check(e_last ? "R4" : "R3", "out_last", 32'(out_last), 32'(e_last));
            end
        end
    end

    task automatic run_burst(input int n, input int len, input bit junk,
                             input bit chg, input bit skew);
        int k;
        int cyc_i;
        @(negedge clk);
        cfg_lanes = 2'(n - 1); lane_hs = '0; lane_valid = '0; lane_data = '0;
        repeat (2) @(negedge clk);
        k = 0; cyc_i = 0;
        while (k < len) begin
            @(negedge clk);
            cyc_i++;
            lane_hs = 4'hF; lane_valid = '0; lane_data = '0;
            if (chg && cyc_i == 2) cfg_lanes = 2'(n % 4);
            for (int i = n; i < 4; i++) begin
                if (junk) begin
                    lane_data[8*i +: 8] = 8'hC3 ^ 8'(cyc_i);
                    lane_valid[i] = cyc_i[0];
                end
            end
            if (cyc_i % 3 != 0) begin
                for (int i = 0; i < n; i++) begin
                    lane_data[8*i +: 8] = 8'(seed + k + i);
                    lane_valid[i] = 1'b1;
                end
                if (skew && k == n) lane_valid[n-1] = 1'b0;
                k += n;
            end
        end
        seed += len;
        @(negedge clk);
        lane_hs = '0; lane_valid = '0; lane_data = '0;
        if (junk) for (int i = n; i < 4; i++) lane_hs[i] = 1'b1;
        repeat (3) @(negedge clk);
        lane_hs = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9", "out_valid", 32'(out_valid), 32'd0);
        check("R9", "out_last", 32'(out_last), 32'd0);
        check("R9", "out_be", 32'(out_be), 32'd0);
        check("R9", "out_data", out_data, 32'd0);
        check("R9", "sync_err", 32'(sync_err), 32'd0);
        rst_n = 1'b1;

        // R1, R2, R3: every lane count, full words only
        cur_req = "R1";
        run_burst(1, 8, 0, 0, 0);
        run_burst(2, 8, 0, 0, 0);
        run_burst(3, 12, 0, 0, 0);
        run_burst(4, 16, 0, 0, 0);
        cur_req = "R2";
        run_burst(4, 12, 0, 0, 0);
        run_burst(3, 24, 0, 0, 0);
        // R4: each partial remainder
        cur_req = "R4";
        run_burst(1, 5, 0, 0, 0);
        run_burst(2, 6, 0, 0, 0);
        run_burst(1, 7, 0, 0, 0);
        run_burst(3, 9, 0, 0, 0);
        run_burst(3, 15, 0, 0, 0);
        // R5: lane setting changed mid-burst
        cur_req = "R5";
        run_burst(2, 10, 0, 1, 0);
        run_burst(3, 9, 0, 1, 0);
        run_burst(1, 7, 0, 1, 0);
        // R7: activity on unused lanes
        cur_req = "R7";
        run_burst(1, 9, 1, 0, 0);
        run_burst(2, 14, 1, 0, 0);
        run_burst(3, 15, 1, 0, 0);
        // R8: valid without a burst
        cur_req = "R8";
        @(negedge clk);
        cfg_lanes = 2'd3;
        repeat (2) @(negedge clk);
        lane_valid = 4'hF; lane_data = 32'h5A5A_5A5A;
        repeat (4) @(negedge clk);
        lane_valid = '0; lane_data = '0;
        repeat (2) @(negedge clk);
        check("R8", "no word outside burst", 32'(out_valid), 32'd0);
        check("R6", "no error before skew", 32'(sync_err), 32'd0);
        // R6: one lane drops valid in a burst
        cur_req = "R6";
        run_burst(2, 10, 0, 0, 1);
        check("R6", "error raised", 32'(sync_err), 32'd1);
        run_burst(4, 12, 0, 0, 0);
        check("R6", "error sticky", 32'(sync_err), 32'd1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule